// File: doc/BRIEF.md
# Cassette Tape Frame Encoder

This block turns a block of bytes into a one-bit audio-level signal for a cassette recorder. A host pulses a start input and presents a file name and a 16-bit byte count at that moment. The block then sends the following pieces in order, each as a square wave:

- a leader tone;
- a header made of the name bytes and the count;
- the data bytes, taken from a valid/ready stream;
- one checksum byte.

Each bit is written as a number of whole square-wave cycles: one cycle for a 0, two cycles for a 1. A bit's duration therefore depends on its value.

The half-cycle length is derived from the system clock frequency and the nominal 0-bit cycle time (855 µs), rounded to a whole number of clocks. Data bytes arrive already fetched from memory.

The data stream follows valid/ready rules:

- Ready is high only while the encoder waits for the next data byte.
- A byte moves on the clock edge where both valid and ready are high.
- The host may raise valid early and may hold its data.
- If valid stays low, the encoder holds the line low and waits. No bit is ever stretched, so back-pressure only inserts idle time between bytes.

Top module: `tape_frame_enc`

## Requirements
- R1: The half-cycle lasts HALF = round(CLK_HZ * CYCLE_NS / 2e9) clocks. A 0 bit is one cycle: HALF clocks high, then HALF clocks low.
- R2: A 1 bit is two such cycles back to back. Bits go out most significant first, and the bits of one byte follow each other with no gap.
- R3: After a start is taken, the line stays low for one request clock and then sends LEADER_CYCLES cycles of leader. Every following byte is also preceded by exactly one low request clock.
- R4: The header carries NAME_BYTES name bytes, then the high byte of the count, then its low byte. Name byte k is name_i[8k+7:8k], and byte 0 goes first.
- R5: Exactly len_i data bytes follow the header. A count of zero sends no data bytes.
- R6: The last byte is the XOR of every header byte and every data byte, starting from zero.
- R7: busy_o rises on the clock after a start is sampled while idle. It falls after the last low phase of the checksum byte. The line is low whenever busy_o is low. A start seen while busy has no effect.
- R8: s_ready_o is high only in a data request clock. While valid is low the line stays low. A byte is taken on the edge where valid and ready are both high, and ready is then low until that byte's last bit ends.
- R9: During reset, tape_o, busy_o and s_ready_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| name_i | input | NAME_BYTES*8 | File name, byte 0 in bits 7:0 |
| len_i | input | 16 | Data byte count |
| s_valid_i | input | 1 | Data byte valid |
| s_data_i | input | 8 | Data byte |
| s_ready_o | output | 1 | Encoder takes a data byte this cycle |
| tape_o | output | 1 | Audio-level output line |
| busy_o | output | 1 | Frame in progress |

## Verification
Two events can fall in the same cycle: the end of the checksum's last low phase and a start request. The bench raises start in the middle of a frame and holds it high across the frame's last clock. The reference model then expects the request to be ignored during that clock, and expects a fresh frame to begin on the very next edge. A second case lets a data byte's valid arrive early, before ready, or late after several stalled request clocks. Each case is judged clock by clock against the model's line, busy and ready levels.

// File: rtl/tfe_pkg.sv
`timescale 1ns/1ps
package tfe_pkg;
  typedef enum logic [2:0] {
    SEG_LEAD, SEG_NAME, SEG_LENH, SEG_LENL, SEG_DATA, SEG_CSUM
  } seg_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_REQ, ST_RUN
  } st_e;
endpackage

// File: rtl/tfe_pulse_gen.sv
`timescale 1ns/1ps
// Emits ncyc square-wave cycles of HALF clocks per phase; may be rechained on done.
module tfe_pulse_gen #(
  parameter int HALF = 3,
  parameter int CW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] ncyc,
  output logic          line,
  output logic          done
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic          active;
  logic          hi;
  logic [HW-1:0] hcnt;
  logic [CW-1:0] left;
  logic          last_half;

  assign last_half = (hcnt == HW'(HALF - 1));
  assign done      = active && !hi && last_half && (left == CW'(1));
  assign line      = active && hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hi     <= 1'b0;
      hcnt   <= '0;
      left   <= '0;
    end else if (go) begin
      active <= 1'b1;
      hi     <= 1'b1;
      hcnt   <= '0;
      left   <= ncyc;
    end else if (active) begin
      if (last_half) begin
        hcnt <= '0;
        if (hi) begin
          hi <= 1'b0;
        end else if (left == CW'(1)) begin
          active <= 1'b0;
        end else begin
          left <= left - CW'(1);
          hi   <= 1'b1;
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  // A new request may only arrive when idle or on the final clock (seamless bits).
  assert_go_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!active || done));

  // A high phase that is not at its last clock continues high next clock.
  assert_high_phase_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hi && !last_half && !go) |=> line);
endmodule

// File: rtl/tfe_byte_ser.sv
`timescale 1ns/1ps
// Serializes a leader run or one byte (MSB first) into cycle counts.
module tfe_byte_ser #(
  parameter int HALF     = 3,
  parameter int LEAD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lead,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic       line,
  output logic       seg_done
);
  localparam int CW = (LEAD_CYC > 2) ? $clog2(LEAD_CYC + 1) : 2;

  logic [7:0]    sh;
  logic [3:0]    bits_left;
  logic          in_lead;
  logic          pg_go;
  logic [CW-1:0] pg_ncyc;
  logic          pg_done;
  logic          next_bit;

  assign next_bit = pg_done && !in_lead && (bits_left > 4'd1);

  always_comb begin
    pg_go   = 1'b0;
    pg_ncyc = CW'(1);
    if (lead) begin
      pg_go   = 1'b1;
      pg_ncyc = CW'(LEAD_CYC);
    end else if (load) begin
      pg_go   = 1'b1;
      pg_ncyc = byte_in[7] ? CW'(2) : CW'(1);
    end else if (next_bit) begin
      pg_go   = 1'b1;
      pg_ncyc = sh[6] ? CW'(2) : CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bits_left <= '0;
      in_lead   <= 1'b0;
    end else if (lead) begin
      in_lead   <= 1'b1;
      bits_left <= '0;
    end else if (load) begin
      in_lead   <= 1'b0;
      sh        <= byte_in;
      bits_left <= 4'd8;
    end else if (next_bit) begin
      sh        <= {sh[6:0], 1'b0};
      bits_left <= bits_left - 4'd1;
    end
  end

  assign seg_done = pg_done && (in_lead || bits_left == 4'd1);

  tfe_pulse_gen #(.HALF(HALF), .CW(CW)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (pg_go),
    .ncyc  (pg_ncyc),
    .line  (line),
    .done  (pg_done)
  );

  // Request clocks from the sequencer see a quiet line.
  assert_req_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lead || load) |-> !line);
endmodule

// File: rtl/tfe_frame_ctl.sv
`timescale 1ns/1ps
// Frame sequencer: leader, name, count, data stream, checksum.
module tfe_frame_ctl
  import tfe_pkg::*;
#(
  parameter int NAME_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [NAME_BYTES*8-1:0] name,
  input  logic [15:0]             len,
  input  logic                    s_valid,
  input  logic [7:0]              s_data,
  input  logic                    seg_done,
  output logic                    s_ready,
  output logic                    busy,
  output logic                    lead,
  output logic                    load,
  output logic [7:0]              byte_out
);
  localparam int IW = (NAME_BYTES > 1) ? $clog2(NAME_BYTES) : 1;

  st_e                     st;
  seg_e                    seg;
  logic [NAME_BYTES*8-1:0] name_r;
  logic [15:0]             len_r;
  logic [15:0]             left;
  logic [IW-1:0]           idx;
  logic [7:0]              csum;

  always_comb begin
    case (seg)
      SEG_NAME: byte_out = name_r[int'(idx)*8 +: 8];
      SEG_LENH: byte_out = len_r[15:8];
      SEG_LENL: byte_out = len_r[7:0];
      SEG_DATA: byte_out = s_data;
      SEG_CSUM: byte_out = csum;
      default:  byte_out = 8'h00;
    endcase
  end

  assign busy    = (st != ST_IDLE);
  assign s_ready = (st == ST_REQ) && (seg == SEG_DATA);
  assign lead    = (st == ST_REQ) && (seg == SEG_LEAD);
  assign load    = (st == ST_REQ) && (seg != SEG_LEAD) && ((seg != SEG_DATA) || s_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      seg    <= SEG_LEAD;
      name_r <= '0;
      len_r  <= '0;
      left   <= '0;
      idx    <= '0;
      csum   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          name_r <= name;
          len_r  <= len;
          csum   <= '0;
          idx    <= '0;
          seg    <= SEG_LEAD;
          st     <= ST_REQ;
        end
        ST_REQ: begin
          if (lead) st <= ST_RUN;
          if (load) begin
            st <= ST_RUN;
            if (seg != SEG_CSUM) csum <= csum ^ byte_out;
          end
        end
        ST_RUN: if (seg_done) begin
          st <= ST_REQ;
          case (seg)
            SEG_LEAD: begin
              seg <= SEG_NAME;
              idx <= '0;
            end
            SEG_NAME: begin
              if (idx == IW'(NAME_BYTES - 1)) seg <= SEG_LENH;
              else idx <= idx + IW'(1);
            end
            SEG_LENH: seg <= SEG_LENL;
            SEG_LENL: begin
              if (len_r == 16'd0) seg <= SEG_CSUM;
              else begin
                seg  <= SEG_DATA;
                left <= len_r;
              end
            end
            SEG_DATA: begin
              if (left == 16'd1) seg <= SEG_CSUM;
              else left <= left - 16'd1;
            end
            default: st <= ST_IDLE;
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Ready drops after a handshake until the next data request clock.
  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> !s_ready);

  // Busy only ends right after the checksum segment completes.
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(seg_done && seg == SEG_CSUM));

  // A start request in the middle of a frame does not end it.
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(seg_done && seg == SEG_CSUM)) |=> busy);
endmodule

// File: rtl/tape_frame_enc.sv
`timescale 1ns/1ps
module tape_frame_enc #(
  parameter int CLK_HZ        = 3_250_000,
  parameter int CYCLE_NS      = 855_000,
  parameter int LEADER_CYCLES = 4096,
  parameter int NAME_BYTES    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NAME_BYTES*8-1:0] name_i,
  input  logic [15:0]             len_i,
  input  logic                    s_valid_i,
  input  logic [7:0]              s_data_i,
  output logic                    s_ready_o,
  output logic                    tape_o,
  output logic                    busy_o
);
  localparam longint unsigned PROD = 64'(CLK_HZ) * 64'(CYCLE_NS);
  localparam int HALF_RAW  = int'((PROD + 64'd1_000_000_000) / 64'd2_000_000_000);
  localparam int HALF_CLKS = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic       lead;
  logic       load;
  logic [7:0] byte_val;
  logic       seg_done;

  tfe_frame_ctl #(.NAME_BYTES(NAME_BYTES)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .name     (name_i),
    .len      (len_i),
    .s_valid  (s_valid_i),
    .s_data   (s_data_i),
    .seg_done (seg_done),
    .s_ready  (s_ready_o),
    .busy     (busy_o),
    .lead     (lead),
    .load     (load),
    .byte_out (byte_val)
  );

  tfe_byte_ser #(.HALF(HALF_CLKS), .LEAD_CYC(LEADER_CYCLES)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .lead     (lead),
    .load     (load),
    .byte_in  (byte_val),
    .line     (tape_o),
    .seg_done (seg_done)
  );

  // The line is quiet outside a frame.
  assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tape_o |-> busy_o);

  // While waiting on the stream the line is held low.
  assert_wait_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> !tape_o);
endmodule

// File: tb/test_tape_frame_enc.sv
`timescale 1ns/1ps
module test_tape_frame_enc;
  localparam int CLK_HZ = 7000;
  localparam int LEAD   = 5;
  localparam int NB     = 3;
  localparam int HALF   = $rtoi(real'(CLK_HZ) * 855000.0 / 2.0e9 + 0.5);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NB*8-1:0] name = '0;
  logic [15:0]   len = '0;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = '0;
  logic          s_ready, tape, busy;

  int  vectors = 0;
  int  fails = 0;
  bit  done_flag = 0;
  logic  exp_line = 0, exp_busy = 0, exp_ready = 0;
  string exp_tag = "R7";

  always #2 clk = ~clk;

  tape_frame_enc #(.CLK_HZ(CLK_HZ), .CYCLE_NS(855_000), .LEADER_CYCLES(LEAD),
                   .NAME_BYTES(NB)) i_tape_frame_enc (
    .clk(clk), .rst_n(rst_n), .start_i(start), .name_i(name), .len_i(len),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .tape_o(tape), .busy_o(busy));

  // ---------------- reference model ----------------
  task automatic m_set(logic l, logic b, logic r, string tag);
    #1;
    exp_line = l; exp_busy = b; exp_ready = r; exp_tag = tag;
  endtask

  task automatic m_step(logic l, string tag);
    m_set(l, 1'b1, 1'b0, tag);
    @(posedge clk);
  endtask

  task automatic m_byte(logic [7:0] b, string tag);
    for (int i = 7; i >= 0; i--) begin
      string t = {tag, b[i] ? "/R2" : "/R1"};
      for (int c = 0; c < (b[i] ? 2 : 1); c++) begin
        repeat (HALF) m_step(1'b1, t);
        repeat (HALF) m_step(1'b0, t);
      end
    end
  endtask

  task automatic m_frame();
    logic [NB*8-1:0] nm = name;
    logic [15:0]     ln = len;
    logic [7:0]      cs = 8'h00;
    logic [7:0]      b;
    m_step(1'b0, "R3");
    repeat (LEAD) begin
      repeat (HALF) m_step(1'b1, "R3");
      repeat (HALF) m_step(1'b0, "R3");
    end
    for (int k = 0; k < NB; k++) begin
      m_step(1'b0, "R3");
      b = nm[k*8 +: 8]; cs ^= b;
      m_byte(b, "R4");
    end
    m_step(1'b0, "R3"); cs ^= ln[15:8]; m_byte(ln[15:8], "R4");
    m_step(1'b0, "R3"); cs ^= ln[7:0];  m_byte(ln[7:0], "R4");
    for (int d = 0; d < int'(ln); d++) begin
      forever begin
        m_set(1'b0, 1'b1, 1'b1, "R8");
        @(posedge clk);
        if (s_valid) break;
      end
      b = s_data; cs ^= b;
      m_byte(b, "R5");
    end
    m_step(1'b0, "R3");
    m_byte(cs, "R6");
    m_set(1'b0, 1'b0, 1'b0, "R7");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && start) m_frame();
    end
  end

  // ---------------- comparison every clock ----------------
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      vectors++;
      if (tape !== exp_line) begin
        fails++;
        $display("FAIL %s tape_o actual=%b expected=%b t=%0t", exp_tag, tape, exp_line, $time);
      end
      if (busy !== exp_busy) begin
        fails++;
        $display("FAIL R7 busy_o actual=%b expected=%b t=%0t", busy, exp_busy, $time);
      end
      if (s_ready !== exp_ready) begin
        fails++;
        $display("FAIL R8 s_ready_o actual=%b expected=%b t=%0t", s_ready, exp_ready, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // gap < 0: valid raised before ready; else stall gap request clocks first
  task automatic feed(logic [7:0] b, int gap);
    if (gap < 0) begin
      s_valid = 1'b1; s_data = b;
      while (!s_ready) @(negedge clk);
    end else begin
      while (!s_ready) @(negedge clk);
      repeat (gap) @(negedge clk);
      s_valid = 1'b1; s_data = b;
    end
    @(negedge clk);
    s_valid = 1'b0; s_data = 8'hxx;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    vectors += 3;
    if (tape !== 1'b0) begin fails++; $display("FAIL R9 tape_o actual=%b expected=0", tape); end
    if (busy !== 1'b0) begin fails++; $display("FAIL R9 busy_o actual=%b expected=0", busy); end
    if (s_ready !== 1'b0) begin fails++; $display("FAIL R9 s_ready_o actual=%b expected=0", s_ready); end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Frame 1: valid early, mixed bytes (R1 R2 R4 R5 R6)
    name = {8'h5A, 8'h01, 8'hC3}; len = 16'd3;
    pulse_start();
    feed(8'hFF, -1); feed(8'h00, -1); feed(8'h80, -1);
    wait_idle();

    // Frame 2: zero length (R5)
    name = {8'h00, 8'hFF, 8'h7E}; len = 16'd0;
    pulse_start();
    wait_idle();

    // Frame 3: back-pressure gaps, stray starts while busy (R7 R8)
    name = {8'h33, 8'h44, 8'h01}; len = 16'd4;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    feed(8'h01, 0); feed(8'hA5, 2);
    pulse_start();
    feed(8'h3C, 5); feed(8'h7F, 1);
    wait_idle();

    // Frames 4+5: start held across the last checksum clock (R7)
    name = {8'h10, 8'h20, 8'h30}; len = 16'd2;
    @(negedge clk); start = 1'b1;
    feed(8'hE1, 0); feed(8'h12, -1);
    wait_idle();          // start still high: next edge opens a new frame
    @(negedge clk); start = 1'b0;
    feed(8'h00, 3); feed(8'hFE, 0);
    wait_idle();
    repeat (10) @(negedge clk);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule